// File: doc/BRIEF.md
# Half-Cycle Predictive Peak-Current Controller

This block sets the peak-current reference of a power-factor-corrected boost converter once per AC half period. On each zero-crossing strobe it forms the output-voltage error and updates an integral accumulator. It weights the integral term and a difference term with separate constants, scales their sum by an overall gain, and adds the result to a table-predicted base code. The sum is clamped and driven out as a 12-bit DAC code. In the same cycle it latches the predicted pulse-density delay.

Both results are registered and stay fixed for the whole of the following half-wave. Between strobes, changes on any input have no effect on the outputs. All arithmetic is 16-bit signed and saturating, so a long run of one-sided error cannot fold over into the opposite sign.

Top module: `hc_pred_fb_ctrl`

## Requirements
- R1: After reset, `dac_code` and `delay_out` are 0, and the integral accumulator and the stored previous error are 0.
- R2: `dac_code` and `delay_out` change only on the rising clock edge where `zc_strobe` is 1. On every other edge they keep their values, whatever the other inputs do.
- R3: On a strobe, the error e = `v_set` − `v_out` (both unsigned) is saturated to 16-bit signed. The integral accumulator becomes sat16(I + e).
- R4: The difference term is d = sat16(e − e_prev). e_prev is the error stored at the previous strobe, or 0 for the first strobe after reset.
- R5: The correction is c = sat16((sat16((I·`k_int` + d·`k_dif`) >>> 4) · `k_gain`) >>> 6). Here I is the updated accumulator, the gains are unsigned, and >>> is an arithmetic shift that rounds toward −∞.
- R6: `dac_code` = `pred_dac` + c, clamped to 0 when the sum is negative and to 4095 when it is above 4095. With `k_gain` = 0 it equals `pred_dac`.
- R7: On a strobe, `delay_out` takes the value of `pred_delay`. A prediction of 0, used at the highest power, gives a delay of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_strobe | input | 1 | One-cycle pulse at the AC zero crossing |
| v_out | input | 12 | Sampled output voltage |
| v_set | input | 12 | Output voltage setpoint |
| pred_dac | input | 12 | Predicted base DAC code |
| pred_delay | input | 16 | Predicted pulse-density delay |
| k_int | input | 8 | Integral weight |
| k_dif | input | 8 | Difference weight |
| k_gain | input | 8 | Overall feedback gain |
| dac_code | output | 12 | Peak-current DAC code for the next half-wave |
| delay_out | output | 16 | Pulse-density delay for the next half-wave |

## Verification
The hardest cases to reach are the saturated integral accumulator and the clamps at both ends of the DAC range. The accumulator can only be seen through the DAC code, and it fills slowly, a few thousand counts per strobe. The stimulus therefore includes directed runs of full-scale positive error with maximum weights, long enough to pin the accumulator at its limit. A full-scale negative run follows, so the unwind from the limit and the low clamp are also observed. Random strobes with random gaps, gains and inputs fill in the middle, and input changes between strobes check that the outputs hold.

// File: rtl/hc_pred_fb_ctrl.sv
module hc_pred_fb_ctrl #(
  parameter int VW  = 12,
  parameter int CW  = 12,
  parameter int DW  = 16,
  parameter int DLW = 16,
  parameter int KW  = 8,
  parameter int WSH = 4,
  parameter int GSH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           zc_strobe,
  input  logic [VW-1:0]  v_out,
  input  logic [VW-1:0]  v_set,
  input  logic [CW-1:0]  pred_dac,
  input  logic [DLW-1:0] pred_delay,
  input  logic [KW-1:0]  k_int,
  input  logic [KW-1:0]  k_dif,
  input  logic [KW-1:0]  k_gain,
  output logic [CW-1:0]  dac_code,
  output logic [DLW-1:0] delay_out
);
  localparam int XW = 48;
  localparam logic signed [XW-1:0] SMAX = (48'sd1 <<< (DW-1)) - 48'sd1;
  localparam logic signed [XW-1:0] SMIN = -SMAX - 48'sd1;
  localparam logic signed [XW-1:0] CMAX = (48'sd1 <<< CW) - 48'sd1;

  function automatic logic signed [DW-1:0] sat(input logic signed [XW-1:0] x);
    if (x > SMAX) return DW'(SMAX);
    if (x < SMIN) return DW'(SMIN);
    return DW'(x);
  endfunction

  logic signed [DW-1:0] integ_q, eprev_q;
  logic signed [DW-1:0] err, dif, integ_n, wsc, corr;
  logic signed [VW:0]   err_raw;
  logic signed [XW-1:0] ki_x, kd_x, kg_x, wsum, gprod, tot;
  logic [CW-1:0]        dac_n;

  assign err_raw = $signed({1'b0, v_set}) - $signed({1'b0, v_out});
  assign err     = sat(XW'(err_raw));
  assign dif     = sat(XW'(err) - XW'(eprev_q));
  assign integ_n = sat(XW'(integ_q) + XW'(err));
  assign ki_x    = XW'($signed({1'b0, k_int}));
  assign kd_x    = XW'($signed({1'b0, k_dif}));
  assign kg_x    = XW'($signed({1'b0, k_gain}));
  assign wsum    = XW'(integ_n) * ki_x + XW'(dif) * kd_x;
  assign wsc     = sat(wsum >>> WSH);
  assign gprod   = XW'(wsc) * kg_x;
  assign corr    = sat(gprod >>> GSH);
  assign tot     = XW'($signed({1'b0, pred_dac})) + XW'(corr);

  always_comb begin
    if (tot < 0)         dac_n = '0;
    else if (tot > CMAX) dac_n = '1;
    else                 dac_n = CW'(tot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q   <= '0;
      eprev_q   <= '0;
      dac_code  <= '0;
      delay_out <= '0;
    end else if (zc_strobe) begin
      integ_q   <= integ_n;
      eprev_q   <= err;
      dac_code  <= dac_n;
      delay_out <= pred_delay;
    end
  end
endmodule

// File: rtl/hc_pred_fb_ctrl_chk.sv
module hc_pred_fb_ctrl_chk #(
  parameter int VW  = 12,
  parameter int CW  = 12,
  parameter int DW  = 16,
  parameter int DLW = 16,
  parameter int KW  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 zc_strobe,
  input logic [VW-1:0]        v_out,
  input logic [VW-1:0]        v_set,
  input logic [CW-1:0]        pred_dac,
  input logic [DLW-1:0]       pred_delay,
  input logic [KW-1:0]        k_int,
  input logic [KW-1:0]        k_dif,
  input logic [KW-1:0]        k_gain,
  input logic [CW-1:0]        dac_code,
  input logic [DLW-1:0]       delay_out,
  input logic signed [DW-1:0] integ
);
  localparam logic signed [DW-1:0] IMAX = {1'b0, {(DW-1){1'b1}}};

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_strobe |=> $stable(dac_code) && $stable(delay_out)); // R2
  AST_INT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe && integ == IMAX && v_set >= v_out |=> integ == IMAX); // R3
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe && k_gain == '0 |=> dac_code == $past(pred_dac)); // R6
  AST_NO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe && k_int == '0 && k_dif == '0 |=> dac_code == $past(pred_dac)); // R5
  AST_DELAY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe |=> delay_out == $past(pred_delay)); // R7
endmodule

bind hc_pred_fb_ctrl hc_pred_fb_ctrl_chk #(.VW(VW), .CW(CW), .DW(DW), .DLW(DLW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .zc_strobe(zc_strobe), .v_out(v_out), .v_set(v_set),
  .pred_dac(pred_dac), .pred_delay(pred_delay), .k_int(k_int), .k_dif(k_dif),
  .k_gain(k_gain), .dac_code(dac_code), .delay_out(delay_out), .integ(integ_q));

// File: tb/tb_hc_pred_fb_ctrl.sv
module tb_hc_pred_fb_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc = 1'b0;
  logic [11:0] v_out = '0, v_set = '0, pred_dac = '0;
  logic [15:0] pred_delay = '0;
  logic [7:0]  k_int = '0, k_dif = '0, k_gain = '0;
  logic [11:0] dac_code;
  logic [15:0] delay_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint m_int = 0, m_prev = 0;
  longint exp_dac = 0, exp_dly = 0;

  always #4 clk = ~clk;

  hc_pred_fb_ctrl dut (
    .clk(clk), .rst_n(rst_n), .zc_strobe(zc), .v_out(v_out), .v_set(v_set),
    .pred_dac(pred_dac), .pred_delay(pred_delay), .k_int(k_int), .k_dif(k_dif),
    .k_gain(k_gain), .dac_code(dac_code), .delay_out(delay_out));

  function automatic longint sat16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_strobe();
    longint e, d, c, w, t;
    e = sat16(longint'(v_set) - longint'(v_out));
    d = sat16(e - m_prev);
    m_int = sat16(m_int + e);
    m_prev = e;
    w = sat16((m_int * longint'(k_int) + d * longint'(k_dif)) >>> 4);
    c = sat16((w * longint'(k_gain)) >>> 6);
    t = longint'(pred_dac) + c;
    exp_dac = (t < 0) ? 0 : (t > 4095) ? 4095 : t;
    exp_dly = pred_delay;
  endtask

  task automatic strobe(string req);
    @(negedge clk);
    zc = 1'b1;
    model_strobe();
    @(negedge clk);
    zc = 1'b0;
    chk(req, dac_code, exp_dac);
    chk("R7 delay", delay_out, exp_dly);
  endtask

  task automatic set_in(int vs, int vo, int pd, int pdl, int ki, int kd, int kg);
    v_set = 12'(vs); v_out = 12'(vo); pred_dac = 12'(pd); pred_delay = 16'(pdl);
    k_int = 8'(ki); k_dif = 8'(kd); k_gain = 8'(kg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_int = 0; m_prev = 0; exp_dac = 0; exp_dly = 0;
    @(negedge clk);
    chk("R1 dac after reset", dac_code, 0);
    chk("R1 delay after reset", delay_out, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    do_reset();
    // R4: first strobe after reset, previous error is 0
    set_in(2100, 2000, 1000, 0, 0, 64, 64);
    strobe("R4 first diff");
    chk("R7 zero delay", delay_out, 0);
    // R2: inputs wiggle without strobe
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      set_in($urandom_range(4095), $urandom_range(4095), $urandom_range(4095),
             $urandom_range(65535), $urandom_range(255), $urandom_range(255), $urandom_range(255));
      @(negedge clk);
      chk("R2 hold dac", dac_code, exp_dac);
      chk("R2 hold delay", delay_out, exp_dly);
    end
    // R6: zero gain passes prediction
    set_in(4095, 0, 1234, 77, 255, 255, 0);
    strobe("R6 zero gain");
    do_reset();
    // R3: saturate integral with full positive error, high clamp
    for (int i = 0; i < 12; i++) begin
      set_in(4095, 0, 2000, 5, 255, 0, 255);
      strobe("R3 integ sat high / R6 clamp high");
    end
    set_in(4095, 0, 0, 5, 1, 0, 64);
    strobe("R3 integ pinned at max");
    // R3 unwind and low clamp
    for (int i = 0; i < 20; i++) begin
      set_in(0, 4095, 100, 9, 1, 0, 64);
      strobe("R3 integ unwind / R6 clamp low");
    end
    set_in(0, 4095, 4095, 9, 255, 255, 255);
    strobe("R6 clamp low");
    // R5 random mix
    for (int i = 0; i < 400; i++) begin
      set_in($urandom_range(4095), $urandom_range(4095), $urandom_range(4095),
             $urandom_range(65535), $urandom_range(255), $urandom_range(255), $urandom_range(255));
      if ($urandom_range(3) == 0) set_in(v_set, v_set - 12'($urandom_range(20)), pred_dac,
                                          pred_delay, k_int, k_dif, k_gain);
      strobe("R5 random correction");
      for (int g = 0; g < int'($urandom_range(3)); g++) begin
        @(negedge clk);
        v_set = 12'($urandom_range(4095));
        chk("R2 hold between strobes", dac_code, exp_dac);
      end
    end
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule